// File: doc/BRIEF.md
# Device Function Configuration Header Register File

This block holds the 64-byte type-0 PCI configuration header of a single device function. A host-side agent reaches it through a simple request port: a byte offset, an access width of one, two or four bytes, a write enable and write data. One clock later the block returns a response carrying read data and an error flag. Fields wider than a byte are stored little-endian, so byte offset N within a word is bits 8N+7..8N of that word.

The identity and class fields, the header type, the interrupt pin, the subsystem identifiers and the initial low bits of every base address register (BAR) come from parameters, as does the window size of each of the six BARs. Software writes only a handful of fields, and only with specific access widths. A BAR returns its size mask when all ones is written to it, and the expansion ROM register has its own probe value. Any access that breaks these rules is refused: nothing changes and the error flag pulses for one cycle.

Top module: `cfg_header_regs`

## Requirements
- R1: After reset, the word at 0x00 reads {DEVICE_ID, VENDOR_ID}. Offset 0x08 reads REVISION, 0x09..0x0B hold CLASS_CODE (0x0B is the base class), 0x0E holds HEADER_TYPE, and 0x3D holds INT_PIN. Each BAR (0x10 + 4*i) reads its parameter initial value. Command, status, cache line size, latency timer and interrupt line read zero.
- R2: A read with req_size 1, 2 or 4 at an offset aligned to that size returns the addressed bytes, little-endian and zero-extended to 32 bits, on rsp_rdata in the cycle after the request, with rsp_valid high and rsp_error low.
- R3: A request whose req_size is not 1, 2 or 4 (size 3 in particular), or whose offset is not a multiple of its size, raises rsp_error. rsp_rdata is then zero.
- R4: One-byte writes are accepted only at 0x3C (interrupt line), 0x0C (cache line size) and 0x0D (latency timer). A one-byte write anywhere else raises rsp_error.
- R5: Two-byte writes are accepted only at 0x04 (command), 0x06 (status) and 0x0C (cache line size together with the latency timer). Any other two-byte write raises rsp_error.
- R6: A four-byte write of 0xFFFFFFFF to BAR i makes it read ~(BAR_SIZE_i - 1), ORed with its held low type bits.
- R7: Bit 0 of a BAR marks it as I/O (1) or memory (0). For an I/O BAR the low 2 bits are read-only; for a memory BAR the low 4 bits are. A four-byte write of any other value stores that value with those bits replaced by the held ones.
- R8: A four-byte write of 0xFFFFFFFE to 0x30 makes that register read 0xFFFFFFFF. Any other four-byte value written there is stored unchanged.
- R9: A four-byte write at 0x04 changes only the 16-bit command field and leaves status unchanged. A four-byte write at any other offset that is not a BAR and not 0x30 changes nothing and raises no error.
- R10: A refused request leaves every register unchanged. rsp_error is high for exactly the one response cycle of that request. rsp_valid is high only in the cycle after a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | 6 | Byte offset into the header |
| req_size | input | 3 | Access width in bytes |
| req_wdata | input | 32 | Write data, right-aligned for narrow writes |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_error | output | 1 | The previous request was refused |
| rsp_rdata | output | 32 | Read data, zero-extended; zero on writes and errors |

## Verification
Every result is due exactly one clock edge after its request. rsp_valid, rsp_error and rsp_rdata are registered at the edge that captures the request, and a write is visible to a read issued in the following cycle. The bench drives each request at a falling edge, lets one rising edge capture it, and samples the response at the next falling edge. For writes it then issues a separate read and samples that read's response the same way. To check that the error flag lasts a single cycle, the bench samples once more after an idle edge.

// File: rtl/cfgspace_pkg.sv
package cfgspace_pkg;

    localparam int HDR_BYTES      = 64;
    localparam int HDR_WORDS      = HDR_BYTES / 4;
    localparam int WIDX_W         = $clog2(HDR_WORDS);
    localparam int NUM_BARS       = 6;
    localparam int BAR_FIRST_WORD = 4;
    localparam int BAR_LAST_WORD  = BAR_FIRST_WORD + NUM_BARS - 1;
    localparam int ROM_WORD       = 12;
    localparam int CMD_WORD       = 1;

    localparam logic [5:0] OFF_CMD      = 6'h04;
    localparam logic [5:0] OFF_STATUS   = 6'h06;
    localparam logic [5:0] OFF_CLSIZE   = 6'h0C;
    localparam logic [5:0] OFF_LATENCY  = 6'h0D;
    localparam logic [5:0] OFF_INT_LINE = 6'h3C;

    localparam logic [31:0] ROM_PROBE = 32'hFFFF_FFFE;

    typedef enum logic [1:0] {
        WK_NONE,
        WK_LANES,
        WK_BAR,
        WK_ROM
    } wr_kind_e;

    typedef struct packed {
        logic              err;
        wr_kind_e          kind;
        logic [3:0]        lane_mask;
        logic [WIDX_W-1:0] word_idx;
        logic [1:0]        lane;
    } acc_dec_t;

    function automatic logic size_legal(input logic [2:0] sz);
        return (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
    endfunction

    function automatic logic offset_aligned(input logic [5:0] off, input logic [2:0] sz);
        logic ok;
        case (sz)
            3'd2:    ok = (off[0] == 1'b0);
            3'd4:    ok = (off[1:0] == 2'b00);
            default: ok = 1'b1;
        endcase
        return ok;
    endfunction

    function automatic logic [31:0] width_mask(input logic [2:0] sz);
        logic [31:0] m;
        case (sz)
            3'd1:    m = 32'h0000_00FF;
            3'd2:    m = 32'h0000_FFFF;
            default: m = 32'hFFFF_FFFF;
        endcase
        return m;
    endfunction

    function automatic logic [31:0] bar_fixed_bits(input logic [31:0] cur);
        return cur[0] ? 32'h0000_0003 : 32'h0000_000F;
    endfunction

endpackage

// File: rtl/cfg_access_decode.sv
module cfg_access_decode
    import cfgspace_pkg::*;
(
    input  logic       write,
    input  logic [5:0] offset,
    input  logic [2:0] size,
    output acc_dec_t   dec
);

    logic legal;

    assign legal = size_legal(size) && offset_aligned(offset, size);

    always_comb begin
        dec           = '0;
        dec.kind      = WK_NONE;
        dec.word_idx  = offset[5:2];
        dec.lane      = offset[1:0];
        if (!legal) begin
            dec.err = 1'b1;
        end else if (write) begin
            case (size)
                3'd1: begin
                    if (offset == OFF_INT_LINE || offset == OFF_CLSIZE ||
                        offset == OFF_LATENCY) begin
                        dec.kind      = WK_LANES;
                        dec.lane_mask = 4'b0001 << offset[1:0];
                    end else begin
                        dec.err = 1'b1;
                    end
                end
                3'd2: begin
                    if (offset == OFF_CMD || offset == OFF_STATUS ||
                        offset == OFF_CLSIZE) begin
                        dec.kind      = WK_LANES;
                        dec.lane_mask = 4'b0011 << offset[1:0];
                    end else begin
                        dec.err = 1'b1;
                    end
                end
                default: begin
                    if (int'(offset[5:2]) >= BAR_FIRST_WORD &&
                        int'(offset[5:2]) <= BAR_LAST_WORD) begin
                        dec.kind = WK_BAR;
                    end else if (int'(offset[5:2]) == ROM_WORD) begin
                        dec.kind = WK_ROM;
                    end else if (int'(offset[5:2]) == CMD_WORD) begin
                        dec.kind      = WK_LANES;
                        dec.lane_mask = 4'b0011;
                    end else begin
                        dec.kind = WK_NONE;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/cfg_bar_sizer.sv
module cfg_bar_sizer
    import cfgspace_pkg::*;
#(
    parameter logic [31:0] WINDOW = 32'h0000_1000
) (
    input  logic [31:0] cur,
    input  logic [31:0] wdata,
    output logic [31:0] nxt
);

    localparam logic [31:0] SIZE_MASK = ~(WINDOW - 32'd1);

    logic [31:0] fixed;

    always_comb begin
        fixed = bar_fixed_bits(cur);
        if (wdata == 32'hFFFF_FFFF) begin
            nxt = SIZE_MASK | (cur & fixed);
        end else begin
            nxt = (wdata & ~fixed) | (cur & fixed);
        end
    end

endmodule

// File: rtl/cfg_header_regs.sv
module cfg_header_regs
    import cfgspace_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID     = 16'hC0DE,
    parameter logic [15:0] DEVICE_ID     = 16'h51A7,
    parameter logic [7:0]  REVISION      = 8'h03,
    parameter logic [23:0] CLASS_CODE    = 24'h02_00_00,
    parameter logic [7:0]  HEADER_TYPE   = 8'h00,
    parameter logic [7:0]  INT_PIN       = 8'h01,
    parameter logic [15:0] SUBSYS_VENDOR = 16'hC0DE,
    parameter logic [15:0] SUBSYS_ID     = 16'h0042,
    parameter logic [NUM_BARS*32-1:0] BAR_INIT =
        {32'h0, 32'h0, 32'h0, 32'h0, 32'h0000_0001, 32'h0000_0008},
    parameter logic [NUM_BARS*32-1:0] BAR_SIZE =
        {32'h0, 32'h0, 32'h0, 32'h0, 32'h0000_0100, 32'h0000_1000}
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [5:0]  req_offset,
    input  logic [2:0]  req_size,
    input  logic [31:0] req_wdata,
    output logic        rsp_valid,
    output logic        rsp_error,
    output logic [31:0] rsp_rdata
);

    logic [HDR_WORDS-1:0][31:0] words_q;
    logic [HDR_WORDS-1:0][31:0] rst_img;
    logic [NUM_BARS-1:0][31:0]  bar_next;
    acc_dec_t                   dec;
    logic [31:0]                wlane;
    logic [31:0]                rword;
    logic [WIDX_W-1:0]          bar_sel;

    always_comb begin
        rst_img     = '0;
        rst_img[0]  = {DEVICE_ID, VENDOR_ID};
        rst_img[2]  = {CLASS_CODE, REVISION};
        rst_img[3]  = {8'h00, HEADER_TYPE, 16'h0000};
        for (int i = 0; i < NUM_BARS; i++) begin
            rst_img[BAR_FIRST_WORD + i] = BAR_INIT[i*32 +: 32];
        end
        rst_img[11] = {SUBSYS_ID, SUBSYS_VENDOR};
        rst_img[15] = {16'h0000, INT_PIN, 8'h00};
    end

    cfg_access_decode u_dec (
        .write  (req_write),
        .offset (req_offset),
        .size   (req_size),
        .dec    (dec)
    );

    for (genvar g = 0; g < NUM_BARS; g++) begin : g_bar
        cfg_bar_sizer #(
            .WINDOW (BAR_SIZE[g*32 +: 32])
        ) u_sizer (
            .cur   (words_q[BAR_FIRST_WORD + g]),
            .wdata (req_wdata),
            .nxt   (bar_next[g])
        );
    end

    assign wlane   = req_wdata << {dec.lane, 3'b000};
    assign rword   = words_q[dec.word_idx] >> {dec.lane, 3'b000};
    assign bar_sel = dec.word_idx - WIDX_W'(BAR_FIRST_WORD);

    always_ff @(posedge clk) begin
        if (rst) begin
            words_q   <= rst_img;
            rsp_valid <= 1'b0;
            rsp_error <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_error <= req_valid && dec.err;
            if (req_valid && !dec.err && !req_write) begin
                rsp_rdata <= rword & width_mask(req_size);
            end else begin
                rsp_rdata <= '0;
            end
            if (req_valid && req_write && !dec.err) begin
                case (dec.kind)
                    WK_LANES: begin
                        for (int b = 0; b < 4; b++) begin
                            if (dec.lane_mask[b]) begin
                                words_q[dec.word_idx][b*8 +: 8] <= wlane[b*8 +: 8];
                            end
                        end
                    end
                    WK_BAR: words_q[dec.word_idx] <= bar_next[bar_sel[2:0]];
                    WK_ROM: words_q[ROM_WORD] <= (req_wdata == ROM_PROBE) ?
                                                 32'hFFFF_FFFF : req_wdata;
                    default: ;
                endcase
            end
        end
    end

    // R3
    odd_size_err_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_size == 3'd3) |=> (rsp_error && rsp_rdata == 32'h0));

    // R8
    rom_probe_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && req_size == 3'd4 && req_offset == 6'h30 &&
         req_wdata == ROM_PROBE) |=> (words_q[ROM_WORD] == 32'hFFFF_FFFF));

    // R10
    refused_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && rsp_valid == rsp_valid && dec.err) |=> $stable(words_q));

    // R10
    idle_no_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!rsp_valid && !rsp_error));

    for (genvar k = 0; k < NUM_BARS; k++) begin : g_bar_chk
        // R7
        bar_type_hold_chk: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> $stable(words_q[BAR_FIRST_WORD + k][0]));
    end

endmodule

// File: tb/cfg_header_regs_test.sv
module cfg_header_regs_test;

    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic        req_write;
    logic [5:0]  req_offset;
    logic [2:0]  req_size;
    logic [31:0] req_wdata;
    logic        rsp_valid;
    logic        rsp_error;
    logic [31:0] rsp_rdata;

    int checks = 0;
    int errors = 0;
    logic [31:0] got_data;
    logic        got_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_header_regs uut (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_offset (req_offset),
        .req_size   (req_size),
        .req_wdata  (req_wdata),
        .rsp_valid  (rsp_valid),
        .rsp_error  (rsp_error),
        .rsp_rdata  (rsp_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [5:0] off, input logic [2:0] sz,
                          input logic [31:0] data);
        req_valid  = 1'b1;
        req_write  = wr;
        req_offset = off;
        req_size   = sz;
        req_wdata  = data;
        @(posedge clk);
        @(negedge clk);
        req_valid  = 1'b0;
        got_data   = rsp_rdata;
        got_err    = rsp_error;
    endtask

    task automatic rd_expect(input string req, input logic [5:0] off, input logic [2:0] sz,
                             input logic [31:0] exp);
        access(1'b0, off, sz, 32'h0);
        check(req, {31'b0, got_err}, 32'h0);
        check(req, got_data, exp);
    endtask

    task automatic test_reset_state();
        rd_expect("R1 ids", 6'h00, 3'd4, 32'h51A7_C0DE);
        rd_expect("R1 class/rev", 6'h08, 3'd4, 32'h0200_0003);
        rd_expect("R1 bar0 init", 6'h10, 3'd4, 32'h0000_0008);
        rd_expect("R1 bar1 init", 6'h14, 3'd4, 32'h0000_0001);
        rd_expect("R1 int pin/line", 6'h3C, 3'd4, 32'h0000_0100);
        rd_expect("R1 command/status", 6'h04, 3'd4, 32'h0);
    endtask

    task automatic test_narrow_reads();
        rd_expect("R2 halfword", 6'h02, 3'd2, 32'h0000_51A7);
        rd_expect("R2 byte rev", 6'h08, 3'd1, 32'h0000_0003);
        rd_expect("R2 byte class", 6'h0B, 3'd1, 32'h0000_0002);
        rd_expect("R2 subsys", 6'h2E, 3'd2, 32'h0000_0042);
    endtask

    task automatic test_illegal_shapes();
        access(1'b0, 6'h01, 3'd2, 32'h0);
        check("R3 misaligned half err", {31'b0, got_err}, 32'h1);
        check("R3 misaligned half data", got_data, 32'h0);
        access(1'b0, 6'h00, 3'd3, 32'h0);
        check("R3 size3 read err", {31'b0, got_err}, 32'h1);
        access(1'b1, 6'h10, 3'd3, 32'hFFFF_FFFF);
        check("R3 size3 write err", {31'b0, got_err}, 32'h1);
        access(1'b0, 6'h04, 3'd0, 32'h0);
        check("R3 size0 err", {31'b0, got_err}, 32'h1);
        rd_expect("R3 bar0 untouched", 6'h10, 3'd4, 32'h0000_0008);
    endtask

    task automatic test_byte_writes();
        access(1'b1, 6'h3C, 3'd1, 32'h0000_005A);
        check("R4 int line accepted", {31'b0, got_err}, 32'h0);
        rd_expect("R4 int line value", 6'h3C, 3'd4, 32'h0000_015A);
        access(1'b1, 6'h0D, 3'd1, 32'h0000_0033);
        rd_expect("R4 latency value", 6'h0C, 3'd4, 32'h0000_3300);
        access(1'b1, 6'h00, 3'd1, 32'h0000_00EE);
        check("R4 ro byte err", {31'b0, got_err}, 32'h1);
        @(posedge clk);
        @(negedge clk);
        check("R10 error single cycle", {31'b0, rsp_error}, 32'h0);
        check("R10 no rsp when idle", {31'b0, rsp_valid}, 32'h0);
        rd_expect("R10 vendor unchanged", 6'h00, 3'd4, 32'h51A7_C0DE);
    endtask

    task automatic test_half_writes();
        access(1'b1, 6'h0C, 3'd2, 32'h0000_4020);
        check("R5 cls half accepted", {31'b0, got_err}, 32'h0);
        rd_expect("R5 cls+lat value", 6'h0C, 3'd4, 32'h0000_4020);
        access(1'b1, 6'h06, 3'd2, 32'h0000_0210);
        rd_expect("R5 status value", 6'h04, 3'd4, 32'h0210_0000);
        access(1'b1, 6'h08, 3'd2, 32'h0000_FFFF);
        check("R5 ro half err", {31'b0, got_err}, 32'h1);
        rd_expect("R5 rev unchanged", 6'h08, 3'd4, 32'h0200_0003);
    endtask

    task automatic test_bars();
        access(1'b1, 6'h10, 3'd4, 32'hFFFF_FFFF);
        check("R6 sizing no err", {31'b0, got_err}, 32'h0);
        rd_expect("R6 mem bar size", 6'h10, 3'd4, 32'hFFFF_F008);
        access(1'b1, 6'h14, 3'd4, 32'hFFFF_FFFF);
        rd_expect("R6 io bar size", 6'h14, 3'd4, 32'hFFFF_FF01);
        access(1'b1, 6'h18, 3'd4, 32'hFFFF_FFFF);
        rd_expect("R6 zero-size bar", 6'h18, 3'd4, 32'h0000_0000);
        access(1'b1, 6'h10, 3'd4, 32'hABCD_1237);
        rd_expect("R7 mem bar base", 6'h10, 3'd4, 32'hABCD_1238);
        access(1'b1, 6'h14, 3'd4, 32'h0000_C0F2);
        rd_expect("R7 io bar base", 6'h14, 3'd4, 32'h0000_C0F1);
    endtask

    task automatic test_rom();
        access(1'b1, 6'h30, 3'd4, 32'hFFFF_FFFE);
        rd_expect("R8 rom probe", 6'h30, 3'd4, 32'hFFFF_FFFF);
        access(1'b1, 6'h30, 3'd4, 32'h1234_5678);
        rd_expect("R8 rom store", 6'h30, 3'd4, 32'h1234_5678);
    endtask

    task automatic test_word_misc();
        access(1'b1, 6'h04, 3'd4, 32'hDEAD_0007);
        check("R9 cmd word no err", {31'b0, got_err}, 32'h0);
        rd_expect("R9 cmd only", 6'h04, 3'd4, 32'h0210_0007);
        access(1'b1, 6'h00, 3'd4, 32'hFFFF_FFFF);
        check("R9 ignored no err", {31'b0, got_err}, 32'h0);
        rd_expect("R9 ids unchanged", 6'h00, 3'd4, 32'h51A7_C0DE);
        access(1'b1, 6'h2C, 3'd4, 32'h1111_2222);
        rd_expect("R9 subsys unchanged", 6'h2C, 3'd4, 32'h0042_C0DE);
    endtask

    initial begin
        req_valid  = 1'b0;
        req_write  = 1'b0;
        req_offset = '0;
        req_size   = '0;
        req_wdata  = '0;
        rst        = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R10 rsp idle after reset", {30'b0, rsp_valid, rsp_error}, 32'h0);
        test_reset_state();
        test_narrow_reads();
        test_illegal_shapes();
        test_byte_writes();
        test_half_writes();
        test_bars();
        test_rom();
        test_word_misc();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule